// File: doc/BRIEF.md
# Video Timing and Subcarrier Reset Controller

This block keeps the sample, line and field count of a standard-definition video timing generator and runs the colour subcarrier phase accumulator beside it. One asynchronous control input, `ext_rst_in`, can restart that timing. A 2-bit mode input decides what the control input does. It can restart the whole timing, clear only the subcarrier phase at the next field boundary, or do nothing (the real-time-control and unused settings).

The control input passes through a two-flop synchroniser and an edge detector. In timing mode, a rising edge holds the sample and line counters at zero and the field number at 1 for as long as the input stays high. Counting resumes once the input falls, and the phase restarts from zero. In subcarrier mode, a rising edge leaves a request pending. The accumulator is zeroed on the clock that starts the next field, and the field sequence carries on without a break. The field number runs 1..4 for the 4-field standard and 1..8 for the 8-field standard, and it can be read at all times.

The block carries no data stream, so it has no valid/ready handshake. Every pin is a plain level, sampled on the clock.

Top module: `sd_timing_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `h_count`=0, `v_count`=0, `field_num`=1 and `phase`=0.
- R2: Outside a hold, `h_count` advances by one each clock from 0 to H_TOTAL-1 and then wraps to 0. `v_count` advances by one on each such wrap, from 0 to LINES_PER_FIELD-1. A field ends when both counters are at their last value.
- R3: At the end of each field, `field_num` advances by one. With `std_pal`=0 it runs 1,2,3,4 and then returns to 1. With `std_pal`=1 it runs 1..8 and then returns to 1.
- R4: With `mode`=2'b00, a rising edge on `ext_rst_in` is seen after two synchroniser flops. From the third clock edge after the input rises, `h_count`=0, `v_count`=0, `field_num`=1 and `phase`=0. These values hold for as long as the input stays high. Before that edge the counters keep running.
- R5: When `ext_rst_in` falls in mode 2'b00, the zero values remain through the third clock edge after the fall. On the fourth edge counting resumes: `h_count`=1 and `phase`=`freq_word`. The field sequence restarts from field 1.
- R6: In mode 2'b00, a pulse on `ext_rst_in` that is high for exactly one clock period is recognised and produces a timing restart.
- R7: With `mode`=2'b01, a rising edge on `ext_rst_in` leaves a clear pending. `phase` reads 0 on the first cycle of the next field, and the counters and `field_num` continue unchanged. The request is then consumed, so later field boundaries do not clear the phase.
- R8: In mode 2'b01, a rising edge that is detected during the last cycle of a field clears the phase at that same field boundary. The clear is not deferred by one field.
- R9: With `mode`=2'b10 or 2'b11, `ext_rst_in` has no effect on the counters, the field number or the phase.
- R10: Outside a clear, `phase` increases by `freq_word` on every clock, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| std_pal | input | 1 | 0: 4-field sequence, 1: 8-field sequence |
| mode | input | 2 | 00 timing restart, 01 subcarrier clear, 10 real-time control (input ignored), 11 no function |
| ext_rst_in | input | 1 | Asynchronous restart/clear request |
| freq_word | input | 32 | Subcarrier phase increment per clock |
| h_count | output | $clog2(H_TOTAL) | Sample position in the line |
| v_count | output | $clog2(LINES_PER_FIELD) | Line position in the field |
| field_num | output | 4 | Active field number, starting at 1 |
| phase | output | 32 | Subcarrier phase accumulator |

## Verification
The subcarrier clear request and the field boundary that consumes it can fall in the same cycle. The bench provokes this by raising `ext_rst_in` two edges before the last cycle of a field, so that the synchronised edge appears in exactly that cycle. It then expects `phase` to read 0 in the first cycle of the following field, and to read 32·`freq_word` one field later, which shows that no stale request survived. The same pairing is exercised in its ordinary form, with a request raised mid-field. A timing hold that starts in the middle of a line is also checked on the exact edge at which it takes effect.

// File: rtl/sdtr_pkg.sv
package sdtr_pkg;

  typedef enum logic [1:0] {
    MODE_TIMING     = 2'b00,
    MODE_SUBCARRIER = 2'b01,
    MODE_RTC        = 2'b10,
    MODE_NONE       = 2'b11
  } rst_mode_e;

  localparam int FIELD_W       = 4;
  localparam int FIELDS_SHORT  = 4;
  localparam int FIELDS_LONG   = 8;

  function automatic logic [FIELD_W-1:0] last_field(input logic long_seq);
    return long_seq ? FIELD_W'(FIELDS_LONG) : FIELD_W'(FIELDS_SHORT);
  endfunction

endpackage

// File: rtl/sdtr_sync.sv
module sdtr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;

  // R6: an edge is reported for one cycle only
  p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/sdtr_reset_seq.sv
module sdtr_reset_seq
  import sdtr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rst_mode_e mode,
  input  logic      sync_level,
  input  logic      sync_rise,
  input  logic      field_wrap,
  output logic      hold,
  output logic      phase_clear
);
  logic tr_active;
  logic tr_start;
  logic sc_rise;
  logic sc_pending;
  logic sc_fire;

  assign tr_start    = (mode == MODE_TIMING) & sync_rise;
  assign sc_rise     = (mode == MODE_SUBCARRIER) & sync_rise;
  assign hold        = tr_active | tr_start;
  assign sc_fire     = field_wrap & (sc_pending | sc_rise);
  assign phase_clear = hold | sc_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) tr_active <= 1'b0;
    else        tr_active <= hold & sync_level;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       sc_pending <= 1'b0;
    else if (hold)    sc_pending <= 1'b0;
    else if (sc_fire) sc_pending <= 1'b0;
    else if (sc_rise) sc_pending <= 1'b1;
  end

  // R9: inactive modes never start a hold or a clear request
  p_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_RTC || mode == MODE_NONE) && !tr_active && !sc_pending)
      |=> (!tr_active && !sc_pending));
  // R7: subcarrier mode never holds the counters
  p_no_hold_sc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SUBCARRIER && !tr_active) |-> !hold);
  // R7: a request is consumed at the boundary
  p_consume_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (field_wrap && !hold) |=> !sc_pending);
endmodule

// File: rtl/sdtr_counters.sv
module sdtr_counters
  import sdtr_pkg::*;
#(
  parameter int H_TOTAL         = 858,
  parameter int LINES_PER_FIELD = 262,
  localparam int H_W = $clog2(H_TOTAL),
  localparam int V_W = $clog2(LINES_PER_FIELD)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold,
  input  logic               std_pal,
  output logic [H_W-1:0]     h_count,
  output logic [V_W-1:0]     v_count,
  output logic [FIELD_W-1:0] field_num,
  output logic               field_wrap
);
  localparam logic [H_W-1:0] H_LAST = H_W'(H_TOTAL - 1);
  localparam logic [V_W-1:0] V_LAST = V_W'(LINES_PER_FIELD - 1);

  logic                line_end;
  logic [FIELD_W-1:0]  seq_last;

  assign line_end   = (h_count == H_LAST);
  assign field_wrap = line_end & (v_count == V_LAST);
  assign seq_last   = last_field(std_pal);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      h_count <= '0;
    end else if (line_end) begin
      h_count <= '0;
    end else begin
      h_count <= h_count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      v_count <= '0;
    end else if (field_wrap) begin
      v_count <= '0;
    end else if (line_end) begin
      v_count <= v_count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hold) begin
      field_num <= FIELD_W'(1);
    end else if (field_wrap) begin
      field_num <= (field_num >= seq_last) ? FIELD_W'(1) : field_num + 1'b1;
    end
  end

  // R4: a hold leaves the counters at their start values
  p_hold_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (h_count == '0 && v_count == '0 && field_num == FIELD_W'(1)));
  // R2: sample counter steps by one inside a line
  p_h_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !line_end) |=> (h_count == $past(h_count) + 1'b1 && v_count == $past(v_count)));
  // R3: sequence returns to field 1 after the last field
  p_field_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && field_wrap && field_num >= seq_last) |=> field_num == FIELD_W'(1));
  // R3: field number never leaves 1..8
  p_field_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (field_num >= FIELD_W'(1) && field_num <= FIELD_W'(FIELDS_LONG)));
endmodule

// File: rtl/sdtr_phase.sv
module sdtr_phase #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [PHASE_W-1:0] freq_word,
  output logic [PHASE_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) phase <= '0;
    else                 phase <= phase + freq_word;
  end

  // R7: a clear zeroes the accumulator on the next cycle
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> phase == '0);
  // R10: accumulate modulo 2^PHASE_W
  p_accum_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> phase == $past(phase) + $past(freq_word));
endmodule

// File: rtl/sd_timing_reset_ctrl.sv
module sd_timing_reset_ctrl
  import sdtr_pkg::*;
#(
  parameter int H_TOTAL         = 858,
  parameter int LINES_PER_FIELD = 262,
  parameter int PHASE_W         = 32,
  parameter int SYNC_STAGES     = 2,
  localparam int H_W = $clog2(H_TOTAL),
  localparam int V_W = $clog2(LINES_PER_FIELD)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               std_pal,
  input  logic [1:0]         mode,
  input  logic               ext_rst_in,
  input  logic [PHASE_W-1:0] freq_word,
  output logic [H_W-1:0]     h_count,
  output logic [V_W-1:0]     v_count,
  output logic [FIELD_W-1:0] field_num,
  output logic [PHASE_W-1:0] phase
);
  logic      sync_level;
  logic      sync_rise;
  logic      field_wrap;
  logic      hold;
  logic      phase_clear;
  rst_mode_e mode_e;

  assign mode_e = rst_mode_e'(mode);

  sdtr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_rst_in),
    .level    (sync_level),
    .rise     (sync_rise)
  );

  sdtr_reset_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode_e),
    .sync_level  (sync_level),
    .sync_rise   (sync_rise),
    .field_wrap  (field_wrap),
    .hold        (hold),
    .phase_clear (phase_clear)
  );

  sdtr_counters #(
    .H_TOTAL         (H_TOTAL),
    .LINES_PER_FIELD (LINES_PER_FIELD)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .std_pal    (std_pal),
    .h_count    (h_count),
    .v_count    (v_count),
    .field_num  (field_num),
    .field_wrap (field_wrap)
  );

  sdtr_phase #(.PHASE_W(PHASE_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (phase_clear),
    .freq_word (freq_word),
    .phase     (phase)
  );

  // R5: the hold covers the phase as well as the counters
  p_hold_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (phase == '0 && h_count == '0));
endmodule

// File: tb/sd_timing_reset_ctrl_tb.sv
module sd_timing_reset_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HT = 8;
  localparam int LT = 4;
  localparam int FLEN = HT * LT;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        std_pal = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        ext_rst_in = 1'b0;
  logic [31:0] freq_word = 32'd5;
  logic [2:0]  h_count;
  logic [1:0]  v_count;
  logic [3:0]  field_num;
  logic [31:0] phase;

  int n_checks = 0;
  int n_fail = 0;
  int n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_timing_reset_ctrl #(.H_TOTAL(HT), .LINES_PER_FIELD(LT)) u_dut (
    .clk(clk), .rst_n(rst_n), .std_pal(std_pal), .mode(mode),
    .ext_rst_in(ext_rst_in), .freq_word(freq_word),
    .h_count(h_count), .v_count(v_count), .field_num(field_num), .phase(phase)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at n=%0d: actual=%0h expected=%0h", tag, n, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
    n += k;
  endtask

  task automatic step_to(input int t);
    step(t - n);
  endtask

  task automatic chk_pos(input string tag, input int h, input int v, input int f);
    chk({tag, " h"}, 32'(h_count), 32'(h));
    chk({tag, " v"}, 32'(v_count), 32'(v));
    chk({tag, " field"}, 32'(field_num), 32'(f));
  endtask

  task automatic do_reset(input logic pal, input logic [1:0] md, input logic [31:0] f);
    @(negedge clk);
    rst_n = 1'b0; std_pal = pal; mode = md; freq_word = f; ext_rst_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    rst_n = 1'b0; freq_word = 32'd5;
    repeat (3) @(negedge clk);
    chk_pos("R1 in reset", 0, 0, 1);
    chk("R1 in reset phase", phase, 32'd0);
    rst_n = 1'b1; n = 0;
    chk_pos("R1 first cycle", 0, 0, 1);
    step(1);
    chk("R10 phase one step", phase, 32'd5);
  endtask

  task automatic t_count_short;
    do_reset(1'b0, 2'b10, 32'd5);
    step_to(7);   chk_pos("R2 end of line", 7, 0, 1);
    step_to(8);   chk_pos("R2 line wrap", 0, 1, 1);
    step_to(31);  chk_pos("R2 last of field", 7, 3, 1);
    step_to(32);  chk_pos("R3 field 2", 0, 0, 2);
    step_to(96);  chk_pos("R3 field 4", 0, 0, 4);
    step_to(128); chk_pos("R3 short wrap", 0, 0, 1);
    chk("R10 phase accum", phase, 32'd640);
  endtask

  task automatic t_count_long;
    do_reset(1'b1, 2'b10, 32'd5);
    step_to(4*FLEN); chk_pos("R3 long field 5", 0, 0, 5);
    step_to(7*FLEN); chk_pos("R3 long field 8", 0, 0, 8);
    step_to(8*FLEN); chk_pos("R3 long wrap", 0, 0, 1);
  endtask

  task automatic t_timing_hold;
    do_reset(1'b0, 2'b00, 32'd5);
    step_to(40);
    ext_rst_in = 1'b1;
    step(2); chk_pos("R4 not yet held", 2, 1, 2);
    step(1); chk_pos("R4 held", 0, 0, 1);
    chk("R4 held phase", phase, 32'd0);
    step(10); chk_pos("R4 still held", 0, 0, 1);
    chk("R4 still held phase", phase, 32'd0);
    ext_rst_in = 1'b0;
    step(3); chk_pos("R5 hold through release", 0, 0, 1);
    step(1); chk_pos("R5 resumed", 1, 0, 1);
    chk("R5 resumed phase", phase, 32'd5);
    step(FLEN - 1); chk_pos("R5 field 2 after restart", 0, 0, 2);
  endtask

  task automatic t_short_pulse;
    do_reset(1'b0, 2'b00, 32'd7);
    step_to(20);
    ext_rst_in = 1'b1;
    step(1);
    ext_rst_in = 1'b0;
    step(1); chk_pos("R6 before hold", 6, 2, 1);
    step(1); chk_pos("R6 pulse held", 0, 0, 1);
    chk("R6 pulse phase", phase, 32'd0);
    step(2); chk_pos("R6 resumed", 1, 0, 1);
    chk("R6 resumed phase", phase, 32'd7);
  endtask

  task automatic t_subcarrier;
    do_reset(1'b0, 2'b01, 32'd3);
    step_to(40);
    ext_rst_in = 1'b1;
    step(2);
    ext_rst_in = 1'b0;
    step_to(63); chk("R7 phase before boundary", phase, 32'd189);
    chk_pos("R7 counters run", 7, 3, 2);
    step(1); chk("R7 phase cleared", phase, 32'd0);
    chk_pos("R7 field continues", 0, 0, 3);
    step(1); chk("R7 phase restarts", phase, 32'd3);
    step_to(96); chk("R7 request consumed", phase, 32'd96);
    chk_pos("R7 field 4", 0, 0, 4);
  endtask

  task automatic t_collision;
    do_reset(1'b0, 2'b01, 32'd5);
    step_to(29);
    ext_rst_in = 1'b1;
    step_to(31); chk("R8 no early clear", phase, 32'd155);
    step(1); chk("R8 same-boundary clear", phase, 32'd0);
    chk_pos("R8 field 2", 0, 0, 2);
    ext_rst_in = 1'b0;
    step_to(64); chk("R8 no stale request", phase, 32'd160);
    chk_pos("R8 field 3", 0, 0, 3);
  endtask

  task automatic t_ignored(input logic [1:0] md);
    do_reset(1'b0, md, 32'd5);
    step_to(20);
    ext_rst_in = 1'b1;
    step(5);
    chk_pos("R9 counters unaffected", 1, 3, 1);
    ext_rst_in = 1'b0;
    step_to(26); chk_pos("R9 after pulse", 2, 3, 1);
    chk("R9 phase unaffected", phase, 32'd130);
    step_to(64); chk("R9 no boundary clear", phase, 32'd320);
    chk_pos("R9 field 3", 0, 0, 3);
  endtask

  task automatic t_phase_wrap;
    do_reset(1'b0, 2'b10, 32'hF000_0000);
    step(2); chk("R10 modulo wrap", phase, 32'hE000_0000);
    step(1); chk("R10 modulo wrap 2", phase, 32'hD000_0000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_count_short();
    t_count_long();
    t_timing_hold();
    t_short_pulse();
    t_subcarrier();
    t_collision();
    t_ignored(2'b10);
    t_ignored(2'b11);
    t_phase_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule